// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator

This block keeps the interrupt status and interrupt mask bytes for an eight-channel serial controller. The channels are grouped two per block, four blocks in all. Each channel reports three conditions: transmitter ready, receiver ready and break seen. Each condition arrives as a one-cycle set pulse or clear pulse, and each channel owns a fixed set of bits in its block's status byte. The block's status ANDed with its mask drives an interrupt request. Blocks are ORed in pairs onto one of two active-high request lines.

Software reads status bytes and writes mask bytes through a byte register port. It programs an interrupt vector byte through a separate identification-space write. It answers interrupt-acknowledge cycles with that vector. Every port takes a request on each cycle and has no back-pressure. A read or acknowledge always gets its answer, flagged by a valid pulse, exactly one cycle after the request.

Top module: `pbi_irq_aggregator`

## Requirements
- R1: After reset all status bytes, all mask bytes and the vector are zero. Both request lines are low, and reads of any status byte return 0x00.
- R2: Channel n maps to block n/2. An even channel keeps TX-ready, RX-ready and break in bits 0, 1 and 2 of that block's status byte. An odd channel keeps them in bits 4, 5 and 6.
- R3: A set pulse raises its bit and a clear pulse lowers it, and other bits are left alone. When set and clear hit the same bit in the same cycle, set wins.
- R4: Status bits 3 and 7 of every block always read as zero.
- R5: The register port selects the block with address bits [6:5] and forms the register offset as address bits [4:0] XOR 0x01. The status/mask register is offset 0x0B, so address bits [4:0] are 0x0A. A read there returns the status byte as it stood before any update in the same cycle. A write there loads the mask byte. Reads at other offsets return 0x00, and writes there change nothing. Read data comes one cycle after the request, with `reg_rvalid` high for exactly that cycle.
- R6: Line 0 is high when block 0 or block 1 has a nonzero (status AND mask). Line 1 does the same for blocks 2 and 3. A line follows any status or mask change one cycle after the register update.
- R7: A per-block break-clear pulse clears bits 2 and 6 of that block and nothing else. A break set pulse in the same cycle wins.
- R8: An acknowledge at address 0 (line 0) or address 2 (line 1) returns the vector as held before the edge. Any other acknowledge address returns 0x00. The answer comes one cycle later with `ack_rvalid`. Acknowledges do not change status.
- R9: A vector write at identification address 1 loads the vector byte. Vector writes at any other address are ignored.
- R10: A mask write and status events in the same cycle both take effect, and the request line in the following cycle reflects both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_rdy_set | input | 8 | Per-channel TX-ready set pulse |
| tx_rdy_clr | input | 8 | Per-channel TX-ready clear pulse |
| rx_rdy_set | input | 8 | Per-channel RX-ready set pulse |
| rx_rdy_clr | input | 8 | Per-channel RX-ready clear pulse |
| brk_set | input | 8 | Per-channel break set pulse |
| brk_clr_blk | input | 4 | Per-block clear of both break bits |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 8 | Read data |
| vec_we | input | 1 | Identification-space write strobe |
| vec_addr | input | 8 | Identification-space write address |
| vec_wdata | input | 8 | Vector write data |
| ack_req | input | 1 | Interrupt-acknowledge strobe |
| ack_addr | input | 8 | Acknowledge address |
| ack_rvalid | output | 1 | Acknowledge data valid |
| ack_rdata | output | 8 | Acknowledge data |
| irq | output | 2 | Active-high interrupt request lines |

## Verification
Two collisions can happen in a single cycle. A mask write can meet a channel set or clear pulse. A break-clear command can meet a break set pulse or a status read of the same block. The bench sets up these coincidences on purpose in directed steps, then runs a long stretch of random pulses, reads, mask writes, acknowledges and vector writes that overlap freely. A behavioural model applies the stated precedence: the read sees the old byte, and set beats clear. The model is compared with the request lines and both read-back paths on every clock.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned LANE_STRIDE = 4;
  localparam int unsigned KIND_TX     = 0;
  localparam int unsigned KIND_RX     = 1;
  localparam int unsigned KIND_BRK    = 2;
  localparam logic [4:0]  OFF_STATMASK = 5'h0B;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int unsigned lane_bit(int unsigned lane, int unsigned kind);
    return lane * LANE_STRIDE + kind;
  endfunction
endpackage

// File: rtl/pbi_status_bank.sv
module pbi_status_bank
  import pbi_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 4,
  localparam int unsigned NUM_CH    = NUM_BLOCKS * 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_CH-1:0]                tx_set,
  input  logic [NUM_CH-1:0]                tx_clr,
  input  logic [NUM_CH-1:0]                rx_set,
  input  logic [NUM_CH-1:0]                rx_clr,
  input  logic [NUM_CH-1:0]                brk_set,
  input  logic [NUM_BLOCKS-1:0]            brk_clr,
  output logic [NUM_BLOCKS-1:0][BYTE_W-1:0] stat_o
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    byte_t stat_q, stat_d;

    always_comb begin
      stat_d = stat_q;
      if (brk_clr[b]) begin
        stat_d[lane_bit(0, KIND_BRK)] = 1'b0;
        stat_d[lane_bit(1, KIND_BRK)] = 1'b0;
      end
      for (int lane = 0; lane < 2; lane++) begin
        if (tx_clr[b*2+lane]) stat_d[lane_bit(lane, KIND_TX)] = 1'b0;
        if (rx_clr[b*2+lane]) stat_d[lane_bit(lane, KIND_RX)] = 1'b0;
      end
      for (int lane = 0; lane < 2; lane++) begin
        if (tx_set[b*2+lane])  stat_d[lane_bit(lane, KIND_TX)]  = 1'b1;
        if (rx_set[b*2+lane])  stat_d[lane_bit(lane, KIND_RX)]  = 1'b1;
        if (brk_set[b*2+lane]) stat_d[lane_bit(lane, KIND_BRK)] = 1'b1;
      end
      stat_d[3] = 1'b0;
      stat_d[7] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
    end

    assign stat_o[b] = stat_q;
  end
endmodule

// File: rtl/pbi_regport.sv
module pbi_regport
  import pbi_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned ID_AW      = 8,
  localparam int unsigned NUM_LINES = NUM_BLOCKS / 2,
  localparam int unsigned BLK_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BLOCKS-1:0][BYTE_W-1:0] stat_i,
  input  logic                              reg_req,
  input  logic                              reg_we,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [BYTE_W-1:0]                 reg_wdata,
  output logic                              reg_rvalid,
  output logic [BYTE_W-1:0]                 reg_rdata,
  input  logic                              vec_we,
  input  logic [ID_AW-1:0]                  vec_addr,
  input  logic [BYTE_W-1:0]                 vec_wdata,
  input  logic                              ack_req,
  input  logic [ID_AW-1:0]                  ack_addr,
  output logic                              ack_rvalid,
  output logic [BYTE_W-1:0]                 ack_rdata,
  output logic [NUM_BLOCKS-1:0][BYTE_W-1:0] mask_o
);
  logic [BLK_W-1:0] blk_sel;
  logic [4:0]       reg_off;
  logic             hit_sm;
  logic             ack_known;
  byte_t            vec_q;

  assign blk_sel = reg_addr[ADDR_W-1 -: BLK_W];
  assign reg_off = reg_addr[4:0] ^ 5'h01;
  assign hit_sm  = (reg_off == OFF_STATMASK);

  always_comb begin
    ack_known = 1'b0;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (ack_addr == ID_AW'(2 * l)) ack_known = 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_mask
    byte_t mask_q;
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else if (reg_req && reg_we && hit_sm && blk_sel == BLK_W'(b)) mask_q <= reg_wdata;
    end
    assign mask_o[b] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
      ack_rvalid <= 1'b0;
      ack_rdata  <= '0;
      vec_q      <= '0;
    end else begin
      reg_rvalid <= reg_req && !reg_we;
      if (reg_req && !reg_we) reg_rdata <= hit_sm ? stat_i[blk_sel] : '0;
      ack_rvalid <= ack_req;
      if (ack_req) ack_rdata <= ack_known ? vec_q : '0;
      if (vec_we && vec_addr == ID_AW'(1)) vec_q <= vec_wdata;
    end
  end
endmodule

// File: rtl/pbi_line_merge.sv
module pbi_line_merge
  import pbi_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 4,
  localparam int unsigned NUM_LINES = NUM_BLOCKS / 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_BLOCKS-1:0][BYTE_W-1:0] stat_i,
  input  logic [NUM_BLOCKS-1:0][BYTE_W-1:0] mask_i,
  output logic [NUM_LINES-1:0]              irq_o
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic pend;
    assign pend = |((stat_i[2*l] & mask_i[2*l]) | (stat_i[2*l+1] & mask_i[2*l+1]));
    always_ff @(posedge clk) begin
      if (!rst_n) irq_o[l] <= 1'b0;
      else        irq_o[l] <= pend;
    end
  end
endmodule

// File: rtl/pbi_irq_aggregator.sv
module pbi_irq_aggregator
  import pbi_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned ID_AW      = 8,
  localparam int unsigned NUM_CH    = NUM_BLOCKS * 2,
  localparam int unsigned NUM_LINES = NUM_BLOCKS / 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     tx_rdy_set,
  input  logic [NUM_CH-1:0]     tx_rdy_clr,
  input  logic [NUM_CH-1:0]     rx_rdy_set,
  input  logic [NUM_CH-1:0]     rx_rdy_clr,
  input  logic [NUM_CH-1:0]     brk_set,
  input  logic [NUM_BLOCKS-1:0] brk_clr_blk,
  input  logic                  reg_req,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic                  reg_rvalid,
  output logic [7:0]            reg_rdata,
  input  logic                  vec_we,
  input  logic [ID_AW-1:0]      vec_addr,
  input  logic [7:0]            vec_wdata,
  input  logic                  ack_req,
  input  logic [ID_AW-1:0]      ack_addr,
  output logic                  ack_rvalid,
  output logic [7:0]            ack_rdata,
  output logic [NUM_LINES-1:0]  irq
);
  logic [NUM_BLOCKS-1:0][BYTE_W-1:0] stat_w;
  logic [NUM_BLOCKS-1:0][BYTE_W-1:0] mask_w;

  pbi_status_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .tx_set(tx_rdy_set), .tx_clr(tx_rdy_clr),
    .rx_set(rx_rdy_set), .rx_clr(rx_rdy_clr),
    .brk_set(brk_set), .brk_clr(brk_clr_blk),
    .stat_o(stat_w)
  );

  pbi_regport #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .ID_AW(ID_AW)) u_port (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_w),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .vec_we(vec_we), .vec_addr(vec_addr), .vec_wdata(vec_wdata),
    .ack_req(ack_req), .ack_addr(ack_addr),
    .ack_rvalid(ack_rvalid), .ack_rdata(ack_rdata),
    .mask_o(mask_w)
  );

  pbi_line_merge #(.NUM_BLOCKS(NUM_BLOCKS)) u_merge (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_w), .mask_i(mask_w), .irq_o(irq)
  );
endmodule

// File: rtl/pbi_checker.sv
module pbi_checker #(
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned ID_AW      = 8,
  localparam int unsigned NUM_CH    = NUM_BLOCKS * 2,
  localparam int unsigned NUM_LINES = NUM_BLOCKS / 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_BLOCKS-1:0][7:0]  stat,
  input logic [NUM_BLOCKS-1:0][7:0]  mask,
  input logic [NUM_LINES-1:0]        irq,
  input logic [NUM_CH-1:0]           brk_set,
  input logic                        reg_req,
  input logic                        reg_we,
  input logic                        reg_rvalid,
  input logic                        ack_req,
  input logic [ID_AW-1:0]            ack_addr,
  input logic                        ack_rvalid,
  input logic [7:0]                  ack_rdata
);
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line_chk
    AST_LINE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (|((stat[2*l] & mask[2*l]) | (stat[2*l+1] & mask[2*l+1]))) |=> irq[l]); // R6
    AST_LINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|((stat[2*l] & mask[2*l]) | (stat[2*l+1] & mask[2*l+1]))) |=> !irq[l]); // R6
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk_chk
    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[b][3] && !stat[b][7]); // R4
    AST_BRK_EVEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      brk_set[2*b] |=> stat[b][2]); // R7
    AST_BRK_ODD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      brk_set[2*b+1] |=> stat[b][6]); // R7
  end

  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we) |=> reg_rvalid); // R5
  AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_req && !reg_we) |=> !reg_rvalid); // R5
  AST_ACK_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_rvalid); // R8
  AST_ACK_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && (ack_addr[0] || ack_addr >= ID_AW'(2 * NUM_LINES))) |=> (ack_rdata == 8'h00)); // R8
endmodule

bind pbi_irq_aggregator pbi_checker #(.NUM_BLOCKS(NUM_BLOCKS), .ID_AW(ID_AW)) u_pbi_checker (
  .clk(clk), .rst_n(rst_n), .stat(stat_w), .mask(mask_w), .irq(irq),
  .brk_set(brk_set), .reg_req(reg_req), .reg_we(reg_we), .reg_rvalid(reg_rvalid),
  .ack_req(ack_req), .ack_addr(ack_addr), .ack_rvalid(ack_rvalid), .ack_rdata(ack_rdata)
);

// File: tb/test_pbi_irq_aggregator.sv
module test_pbi_irq_aggregator;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_rdy_set = '0, tx_rdy_clr = '0, rx_rdy_set = '0, rx_rdy_clr = '0, brk_set = '0;
  logic [3:0] brk_clr_blk = '0;
  logic       reg_req = 1'b0, reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rvalid;
  logic [7:0] reg_rdata;
  logic       vec_we = 1'b0;
  logic [7:0] vec_addr = '0, vec_wdata = '0;
  logic       ack_req = 1'b0;
  logic [7:0] ack_addr = '0;
  logic       ack_rvalid;
  logic [7:0] ack_rdata;
  logic [1:0] irq;

  pbi_irq_aggregator i_pbi_irq_aggregator (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  logic [7:0] m_stat [4];
  logic [7:0] m_mask [4];
  logic [7:0] m_vec;
  logic [1:0] m_irq;
  logic       m_rvalid, m_avalid;
  logic [7:0] m_rdata, m_adata;

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < 4; b++) begin m_stat[b] = '0; m_mask[b] = '0; end
    m_vec = '0; m_irq = '0; m_rvalid = 0; m_avalid = 0; m_rdata = '0; m_adata = '0;
  endtask

  task automatic model_step();
    logic [1:0] nirq;
    int b, sh;
    for (int l = 0; l < 2; l++)
      nirq[l] = |((m_stat[2*l] & m_mask[2*l]) | (m_stat[2*l+1] & m_mask[2*l+1]));
    m_rvalid = reg_req && !reg_we;
    if (m_rvalid)
      m_rdata = ((reg_addr[4:0] ^ 5'h01) == 5'h0B) ? m_stat[reg_addr[6:5]] : 8'h00;
    m_avalid = ack_req;
    if (ack_req) m_adata = (ack_addr == 8'd0 || ack_addr == 8'd2) ? m_vec : 8'h00;
    if (vec_we && vec_addr == 8'd1) m_vec = vec_wdata;
    if (reg_req && reg_we && (reg_addr[4:0] ^ 5'h01) == 5'h0B) m_mask[reg_addr[6:5]] = reg_wdata;
    for (int b2 = 0; b2 < 4; b2++)
      if (brk_clr_blk[b2]) begin m_stat[b2][2] = 0; m_stat[b2][6] = 0; end
    for (int ch = 0; ch < 8; ch++) begin
      b = ch / 2; sh = (ch % 2) * 4;
      if (tx_rdy_clr[ch]) m_stat[b][sh]   = 0;
      if (rx_rdy_clr[ch]) m_stat[b][sh+1] = 0;
    end
    for (int ch = 0; ch < 8; ch++) begin
      b = ch / 2; sh = (ch % 2) * 4;
      if (tx_rdy_set[ch]) m_stat[b][sh]   = 1;
      if (rx_rdy_set[ch]) m_stat[b][sh+1] = 1;
      if (brk_set[ch])    m_stat[b][sh+2] = 1;
    end
    m_irq = nirq;
  endtask

  task automatic clear_inputs();
    tx_rdy_set = '0; tx_rdy_clr = '0; rx_rdy_set = '0; rx_rdy_clr = '0; brk_set = '0;
    brk_clr_blk = '0; reg_req = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    vec_we = 0; vec_addr = '0; vec_wdata = '0; ack_req = 0; ack_addr = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R6", "irq", {6'b0, irq}, {6'b0, m_irq});
    check("R5", "reg_rvalid", {7'b0, reg_rvalid}, {7'b0, m_rvalid});
    if (m_rvalid) check(cur_req, "reg_rdata", reg_rdata, m_rdata);
    check("R8", "ack_rvalid", {7'b0, ack_rvalid}, {7'b0, m_avalid});
    if (m_avalid) check(cur_req, "ack_rdata", ack_rdata, m_adata);
    clear_inputs();
  endtask

  function automatic logic [6:0] sm_addr(int b);
    return {b[1:0], 5'h0A};
  endfunction

  task automatic rd(int b);
    reg_req = 1; reg_we = 0; reg_addr = sm_addr(b); tick();
  endtask

  task automatic wr_mask(int b, logic [7:0] v);
    reg_req = 1; reg_we = 1; reg_addr = sm_addr(b); reg_wdata = v; tick();
  endtask

  task automatic read_all(string tag);
    cur_req = tag;
    for (int b = 0; b < 4; b++) begin rd(b); tick(); end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    read_all("R1");
    cur_req = "R1"; ack_req = 1; ack_addr = 8'd0; tick(); tick();
    // R2: channel to bit mapping
    tx_rdy_set = 8'b0000_0001; rx_rdy_set = 8'b0000_1000; brk_set = 8'b0010_0000; tick();
    tx_rdy_set = 8'b0100_0000; rx_rdy_set = 8'b1000_0000; tick();
    read_all("R2");
    // R3: set wins over clear, others untouched
    tx_rdy_set = 8'b0000_0010; tx_rdy_clr = 8'b0000_0011; tick();
    rx_rdy_clr = 8'b1000_1000; tick();
    read_all("R3");
    // R4: every pulse at once, spare bits stay zero
    tx_rdy_set = '1; rx_rdy_set = '1; brk_set = '1; tick();
    read_all("R4");
    // R5: other offsets read zero, write there ignored
    cur_req = "R5";
    reg_req = 1; reg_addr = 7'h2C; tick();
    reg_req = 1; reg_we = 1; reg_addr = 7'h04; reg_wdata = 8'hFF; tick();
    tick(); tick();
    reg_req = 1; reg_addr = 7'h0B; tick(); tick();
    // R6: line per block pair
    wr_mask(1, 8'h20); tick(); tick();
    wr_mask(1, 8'h00); tick();
    wr_mask(2, 8'h04); tick(); tick();
    tx_rdy_clr = '1; rx_rdy_clr = '1; tick(); tick();
    // R7: break clear, concurrent set wins
    brk_clr_blk = 4'b0001; tick();
    read_all("R7");
    brk_clr_blk = 4'b0110; brk_set = 8'b0000_1000; tick();
    read_all("R7");
    cur_req = "R7"; brk_clr_blk = 4'b1000; reg_req = 1; reg_addr = sm_addr(3); tick(); tick();
    // R9: vector writes
    cur_req = "R9";
    vec_we = 1; vec_addr = 8'd1; vec_wdata = 8'hA5; tick();
    vec_we = 1; vec_addr = 8'd0; vec_wdata = 8'h3C; tick();
    vec_we = 1; vec_addr = 8'd3; vec_wdata = 8'h77; tick();
    // R8: acknowledge addresses
    cur_req = "R8";
    for (int a = 0; a < 5; a++) begin ack_req = 1; ack_addr = a[7:0]; tick(); end
    ack_req = 1; ack_addr = 8'd2; vec_we = 1; vec_addr = 8'd1; vec_wdata = 8'h5A; tick();
    ack_req = 1; ack_addr = 8'd2; tick(); tick();
    // R10: mask write with concurrent event
    wr_mask(0, 8'h00);
    reg_req = 1; reg_we = 1; reg_addr = sm_addr(0); reg_wdata = 8'h02; rx_rdy_set = 8'h01; tick(); tick();
    reg_req = 1; reg_we = 1; reg_addr = sm_addr(0); reg_wdata = 8'h00; rx_rdy_set = 8'h02; tick(); tick();
    read_all("R10");
    // random overlap
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      tx_rdy_set = 8'($urandom) & 8'($urandom); tx_rdy_clr = 8'($urandom) & 8'($urandom);
      rx_rdy_set = 8'($urandom) & 8'($urandom); rx_rdy_clr = 8'($urandom) & 8'($urandom);
      brk_set = 8'($urandom) & 8'($urandom) & 8'($urandom);
      brk_clr_blk = 4'($urandom) & 4'($urandom);
      if ($urandom_range(0, 2) == 0) begin
        reg_req = 1; reg_we = ($urandom_range(0, 3) == 0);
        reg_addr = ($urandom_range(0, 4) == 0) ? 7'($urandom) : sm_addr($urandom_range(0, 3));
        reg_wdata = 8'($urandom);
      end
      if ($urandom_range(0, 5) == 0) begin ack_req = 1; ack_addr = 8'($urandom_range(0, 3)); end
      if ($urandom_range(0, 9) == 0) begin vec_we = 1; vec_addr = 8'($urandom_range(0, 2)); vec_wdata = 8'($urandom); end
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule